// File: doc/BRIEF.md
# Two-Phase Reset Sequencer

This block generates the internal reset of a microcontroller from two digital requests: a supply-monitor flag (covering power-up and supply sag) and a one-cycle underflow pulse from a watchdog counter. Any accepted request starts a sequence. First, internal reset is held for a hold phase: a fixed settling portion given in clock cycles, plus 127 cycles. Then reset is released and a silent settle phase of 512 cycles lets the oscillator stabilise. Last, a two-cycle vector fetch presents the two bytes of the reset vector before the block reports the run state.

The supply-monitor flag passes through a deglitcher, so a short spike cannot start the sequence. Any request accepted during any phase, including run, restarts the sequence at the start of the hold phase. A one-bit cause flag records which source started the most recent sequence.

Top module: `rst_sequencer`

## Requirements
- R1: While the block's own reset `rst_n` is low, `core_rst_o` is 1 and `vec_fetch_o` and `run_o` are 0. After `rst_n` rises, a full sequence runs with `reset_by_wdog_o` = 0.
- R2: A 1 on `wdog_uf_i` sampled at a clock edge starts a sequence, and `core_rst_o` is 1 in the following cycle.
- R3: `low_vdd_i` is accepted only once it has been 1 at FILT_CYCLES consecutive clock edges (default 4). A high pulse lasting fewer edges has no effect on any output.
- R4: The hold phase keeps `core_rst_o` at 1 for exactly SETTLE_CYCLES + 127 cycles (default 247), counted from the first cycle after the accepting edge.
- R5: After the hold phase comes a settle phase of exactly 512 cycles with `core_rst_o`, `vec_fetch_o` and `run_o` all 0.
- R6: The fetch phase asserts `vec_fetch_o` for exactly two cycles. `vec_addr_o` is 16'hFFFE in the first cycle and 16'hFFFF in the second. It is 0 whenever `vec_fetch_o` is 0.
- R7: After the fetch, `run_o` is 1 and stays 1 until a new request is accepted.
- R8: A request accepted in any phase (hold, settle, fetch or run) restarts the hold phase with its full length.
- R9: `reset_by_wdog_o` is 1 after a sequence started by the watchdog and 0 after one started by the supply monitor. When both are accepted at the same edge, the supply monitor takes priority and the flag reads 0.
- R10: At most one of `core_rst_o`, `vec_fetch_o` and `run_o` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer itself (power-up) |
| low_vdd_i | input | 1 | Supply-monitor flag, 1 = supply too low |
| wdog_uf_i | input | 1 | Watchdog underflow pulse |
| core_rst_o | output | 1 | Internal reset, active high |
| vec_fetch_o | output | 1 | Reset-vector fetch strobe |
| vec_addr_o | output | 16 | Address of the vector byte being fetched |
| run_o | output | 1 | Sequence complete, core running |
| reset_by_wdog_o | output | 1 | Cause of the last sequence: 1 = watchdog, 0 = supply monitor |

## Verification
A phase counter that is off by one shows up at the ports as a reset pulse or a silent gap one cycle too long or too short. The bench therefore measures each phase length to the exact cycle rather than just waiting for run. A wrong state after a restart request is visible in the very next cycle, because `core_rst_o` must already be high. A wrong deglitch count shows up as a three-cycle spike that drops `run_o`, or as a four-cycle pulse that fails to. A stale or wrongly prioritised cause flag is seen as soon as `run_o` returns.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
    typedef enum logic [1:0] {
        SEQ_HOLD   = 2'd0,
        SEQ_SETTLE = 2'd1,
        SEQ_FETCH  = 2'd2,
        SEQ_RUN    = 2'd3
    } seq_state_e;
endpackage

// File: rtl/rstseq_deglitch.sv
module rstseq_deglitch #(
    parameter int FILT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic accept_o
);
    localparam int FW = $clog2(FILT_CYCLES + 1);

    typedef struct packed {
        logic [FW-1:0] run_len;
    } filt_t;

    filt_t filt_d, filt_q;

    always_comb begin
        filt_d = filt_q;
        if (!level_i) begin
            filt_d.run_len = '0;
        end else if (filt_q.run_len != FW'(FILT_CYCLES)) begin
            filt_d.run_len = filt_q.run_len + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) filt_q <= '0;
        else        filt_q <= filt_d;
    end

    assign accept_o = level_i && (filt_q.run_len >= FW'(FILT_CYCLES - 1));

    // R3: an accepted level has been high for at least two sampled edges
    assert_accept_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> (level_i && $past(level_i)));
endmodule

// File: rtl/rstseq_phase_ctrl.sv
module rstseq_phase_ctrl
    import rstseq_pkg::*;
#(
    parameter int HOLD_LEN   = 247,
    parameter int SETTLE_LEN = 512,
    parameter int CW         = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    output seq_state_e    state_o,
    output logic [CW-1:0] cnt_o
);
    localparam int FETCH_LEN = 2;

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (req_i) begin
            ctrl_d.st  = SEQ_HOLD;
            ctrl_d.cnt = '0;
        end else begin
            unique case (ctrl_q.st)
                SEQ_HOLD: begin
                    if (ctrl_q.cnt == CW'(HOLD_LEN - 1)) begin
                        ctrl_d.st  = SEQ_SETTLE;
                        ctrl_d.cnt = '0;
                    end else begin
                        ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                    end
                end
                SEQ_SETTLE: begin
                    if (ctrl_q.cnt == CW'(SETTLE_LEN - 1)) begin
                        ctrl_d.st  = SEQ_FETCH;
                        ctrl_d.cnt = '0;
                    end else begin
                        ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                    end
                end
                SEQ_FETCH: begin
                    if (ctrl_q.cnt == CW'(FETCH_LEN - 1)) begin
                        ctrl_d.st  = SEQ_RUN;
                        ctrl_d.cnt = '0;
                    end else begin
                        ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                    end
                end
                default: begin
                    ctrl_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.st  <= SEQ_HOLD;
            ctrl_q.cnt <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign state_o = ctrl_q.st;
    assign cnt_o   = ctrl_q.cnt;

    // R8: any request lands the sequencer at the start of the hold phase
    assert_restart_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> (ctrl_q.st == SEQ_HOLD && ctrl_q.cnt == '0));
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
    import rstseq_pkg::*;
#(
    parameter int          SETTLE_CYCLES = 120,
    parameter int          EXTRA_CYCLES  = 127,
    parameter int          STAB_CYCLES   = 512,
    parameter int          FILT_CYCLES   = 4,
    parameter int          ADDR_W        = 16,
    parameter logic [15:0] VECTOR_BASE   = 16'hFFFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              low_vdd_i,
    input  logic              wdog_uf_i,
    output logic              core_rst_o,
    output logic              vec_fetch_o,
    output logic [ADDR_W-1:0] vec_addr_o,
    output logic              run_o,
    output logic              reset_by_wdog_o
);
    localparam int HOLD_LEN = SETTLE_CYCLES + EXTRA_CYCLES;
    localparam int MAX_LEN  = (HOLD_LEN > STAB_CYCLES) ? HOLD_LEN : STAB_CYCLES;
    localparam int CW       = $clog2(MAX_LEN + 1);

    logic          vdd_accept;
    logic          seq_req;
    seq_state_e    seq_state;
    logic [CW-1:0] seq_cnt;

    typedef struct packed {
        logic by_wdog;
    } cause_t;

    cause_t cause_d, cause_q;

    rstseq_deglitch #(
        .FILT_CYCLES(FILT_CYCLES)
    ) u_deglitch (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (low_vdd_i),
        .accept_o(vdd_accept)
    );

    assign seq_req = vdd_accept || wdog_uf_i;

    rstseq_phase_ctrl #(
        .HOLD_LEN  (HOLD_LEN),
        .SETTLE_LEN(STAB_CYCLES),
        .CW        (CW)
    ) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (seq_req),
        .state_o(seq_state),
        .cnt_o  (seq_cnt)
    );

    always_comb begin
        cause_d = cause_q;
        if (vdd_accept)     cause_d.by_wdog = 1'b0;
        else if (wdog_uf_i) cause_d.by_wdog = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= cause_d;
    end

    always_comb begin
        core_rst_o      = (seq_state == SEQ_HOLD);
        vec_fetch_o     = (seq_state == SEQ_FETCH);
        run_o           = (seq_state == SEQ_RUN);
        reset_by_wdog_o = cause_q.by_wdog;
        vec_addr_o      = '0;
        if (seq_state == SEQ_FETCH)
            vec_addr_o = ADDR_W'(VECTOR_BASE) + ADDR_W'(seq_cnt[0]);
    end

    // R1: reset state of the outputs
    always_comb begin
        if (!rst_n) begin
            assert_reset_outputs_R1: assert (core_rst_o && !vec_fetch_o && !run_o);
        end
    end

    // R2: watchdog pulse raises the internal reset one cycle later
    assert_wdog_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_uf_i |=> core_rst_o);

    // R3: a supply flag that only just rose cannot disturb the run state
    assert_spike_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && low_vdd_i && !$past(low_vdd_i) && !wdog_uf_i) |=> run_o);

    // R4: hold phase ends only at its final count
    assert_hold_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst_o) |-> ($past(seq_cnt) == CW'(HOLD_LEN - 1)));

    // R5: fetch begins only after the full settle phase
    assert_settle_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_fetch_o) |-> ($past(seq_state) == SEQ_SETTLE &&
                                $past(seq_cnt) == CW'(STAB_CYCLES - 1)));

    // R6: the low vector byte is followed by the high one
    assert_fetch_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_fetch_o && !vec_addr_o[0] && !seq_req) |=> (vec_fetch_o && vec_addr_o[0]));

    // R7: run holds while no request arrives
    assert_run_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && !seq_req) |=> run_o);

    // R9: supply monitor wins the cause flag
    assert_cause_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vdd_accept |=> !reset_by_wdog_o);

    // R10: phase indicators are mutually exclusive
    assert_onehot_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({core_rst_o, vec_fetch_o, run_o}));
endmodule

// File: tb/rst_sequencer_test.sv
module rst_sequencer_test;
    localparam int HOLD_EXP   = 247;
    localparam int SETTLE_EXP = 512;
    localparam int NVEC       = 8;

    // kind: 0 watchdog pulse, 1 supply pulse, 2 supply pulse with watchdog on its last cycle
    localparam int V_KIND  [NVEC] = '{1, 0, 1, 1, 0, 1, 2, 0};
    localparam int V_LEN   [NVEC] = '{2, 1, 4, 3, 1, 10, 4, 1};
    localparam int V_TRIG  [NVEC] = '{0, 1, 1, 0, 1, 1, 1, 1};
    localparam int V_CAUSE [NVEC] = '{0, 1, 0, 0, 1, 0, 0, 1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        low_vdd_i = 1'b0;
    logic        wdog_uf_i = 1'b0;
    logic        core_rst_o, vec_fetch_o, run_o, reset_by_wdog_o;
    logic [15:0] vec_addr_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rst_sequencer uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .low_vdd_i      (low_vdd_i),
        .wdog_uf_i      (wdog_uf_i),
        .core_rst_o     (core_rst_o),
        .vec_fetch_o    (vec_fetch_o),
        .vec_addr_o     (vec_addr_o),
        .run_o          (run_o),
        .reset_by_wdog_o(reset_by_wdog_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic pulse_wdog();
        wdog_uf_i = 1'b1;
        @(negedge clk);
        wdog_uf_i = 1'b0;
    endtask

    // called at the negedge right after the accepting edge
    task automatic expect_sequence(input int exp_cause, input string tag);
        int n;
        n = 0;
        while (core_rst_o && n < 2000) begin n++; @(negedge clk); end
        check(n == HOLD_EXP, {tag, " R4 hold length"}, n, HOLD_EXP);
        n = 0;
        while (!core_rst_o && !vec_fetch_o && !run_o && n < 2000) begin n++; @(negedge clk); end
        check(n == SETTLE_EXP, {tag, " R5 settle length"}, n, SETTLE_EXP);
        check(vec_fetch_o && vec_addr_o == 16'hFFFE, {tag, " R6 first fetch"}, int'(vec_addr_o), 16'hFFFE);
        @(negedge clk);
        check(vec_fetch_o && vec_addr_o == 16'hFFFF, {tag, " R6 second fetch"}, int'(vec_addr_o), 16'hFFFF);
        @(negedge clk);
        check(run_o && !vec_fetch_o && vec_addr_o == 16'h0, {tag, " R7 run after fetch"}, int'(run_o), 1);
        check(reset_by_wdog_o == exp_cause[0], {tag, " R9 cause"}, int'(reset_by_wdog_o), exp_cause);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(core_rst_o && !vec_fetch_o && !run_o, "R1 reset state", int'(core_rst_o), 1);
        rst_n = 1'b1;
        expect_sequence(0, "R1 power-up");

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            case (V_KIND[i])
                0: begin
                    wdog_uf_i = 1'b1;
                    repeat (V_LEN[i]) @(negedge clk);
                    wdog_uf_i = 1'b0;
                end
                1: begin
                    low_vdd_i = 1'b1;
                    repeat (V_LEN[i]) @(negedge clk);
                    low_vdd_i = 1'b0;
                end
                default: begin
                    low_vdd_i = 1'b1;
                    repeat (V_LEN[i] - 1) @(negedge clk);
                    wdog_uf_i = 1'b1;
                    @(negedge clk);
                    low_vdd_i = 1'b0;
                    wdog_uf_i = 1'b0;
                end
            endcase
            if (V_TRIG[i] != 0) begin
                check(core_rst_o, $sformatf("R2/R3 vector %0d starts reset", i), int'(core_rst_o), 1);
                expect_sequence(V_CAUSE[i], $sformatf("vector %0d", i));
            end else begin
                bit disturbed;
                disturbed = 1'b0;
                for (int k = 0; k < 20; k++) begin
                    if (core_rst_o || !run_o) disturbed = 1'b1;
                    @(negedge clk);
                end
                check(!disturbed, $sformatf("R3 vector %0d spike ignored", i), int'(disturbed), 0);
                check(reset_by_wdog_o == V_CAUSE[i][0], $sformatf("R3 vector %0d cause kept", i),
                      int'(reset_by_wdog_o), V_CAUSE[i]);
            end
        end

        // R8: restart during hold
        pulse_wdog();
        repeat (100) @(negedge clk);
        check(core_rst_o, "R8 still in hold", int'(core_rst_o), 1);
        pulse_wdog();
        expect_sequence(1, "R8 restart in hold");

        // R8: restart during settle
        pulse_wdog();
        while (core_rst_o) @(negedge clk);
        repeat (50) @(negedge clk);
        check(!core_rst_o && !run_o && !vec_fetch_o, "R8 in settle", int'(core_rst_o), 0);
        low_vdd_i = 1'b1;
        repeat (4) @(negedge clk);
        low_vdd_i = 1'b0;
        expect_sequence(0, "R8 restart in settle");

        // R8: restart during fetch
        pulse_wdog();
        for (int k = 0; k < 2000 && !vec_fetch_o; k++) @(negedge clk);
        check(vec_fetch_o, "R8 reached fetch", int'(vec_fetch_o), 1);
        pulse_wdog();
        check(core_rst_o && !vec_fetch_o, "R10 fetch aborted to hold", int'(vec_fetch_o), 0);
        expect_sequence(1, "R8 restart in fetch");

        report();
    end
endmodule